// File: doc/BRIEF.md
# Input Bus Pattern Checker

This block verifies that a parallel sample bus is captured cleanly by comparing every incoming sample with an eight-entry reference pattern. Each entry comes from a programmable register. A rising edge on the sync input marks the sample that lines up with entry 0. Later samples walk through the remaining entries and then wrap. Any bit that differs from its reference sets a sticky alarm bit of its own. Software can use this to find which bus lines fail setup or hold.

The alarm clears in one of two ways. Software can pulse a clear strobe, or the block can clear it by itself after an unbroken run of 64 matching samples. The second way suits a bench where the link settles after start-up. The bus carries either one 14-bit word per sample or two 8-bit half-word lanes. Lane A sits in bits 7:0 and lane B in bits 15:8. When the check enable is low, every register of the checker is held at rest. This stands in for a gated clock, and no alarm is produced.

Top module: `pattern_checker`

## Requirements
- R1: While reset is high, and on the first falling edge after it is released, alarm_out is all zeros.
- R2: Pattern entry k is pat_flat[16k+15:16k]. The sample presented in the cycle sync_in rises from 0 to 1 is compared with entry 0. Each following sample is compared with the next entry, and entry 7 is followed by entry 0.
- R3: After reset or re-enable, samples are not compared until the first sync rising edge, so alarm_out stays zero.
- R4: Each compared bit that differs from its entry sets the matching alarm_out bit at the clock edge that samples it. The bit stays set, and other bits stay unchanged.
- R5: A high alarm_clr clears all alarm bits at the next edge. A bit that mismatches in that same cycle is set anyway.
- R6: With autoclr_en high, the edge that samples the 64th consecutive matching sample clears alarm_out. The run count restarts from zero on any mismatch and on every sync rising edge.
- R7: With autoclr_en low, alarm bits stay set through any number of matching samples.
- R8: With chk_en low, alarm_out reads zero after the next edge and the pattern lock is lost. A new sync rising edge is needed before checking resumes.
- R9: With full_word_mode high (1), only bits 13:0 are compared and bits 15:14 never alarm. With it low (0), both 8-bit lanes (bits 15:0) are compared.
- R10: A sync rising edge in the middle of a run re-aligns the sequence so that the sample in that cycle is compared with entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Checker enable; low holds all checker state idle |
| full_word_mode | input | 1 | 1: single 14-bit word, 0: two 8-bit lanes |
| autoclr_en | input | 1 | Enables self-clear after 64 matching samples |
| alarm_clr | input | 1 | Clears the alarm register (write strobe) |
| sync_in | input | 1 | Sync; rising edge aligns pattern entry 0 |
| sample_in | input | 16 | Sample bus; lane A bits 7:0, lane B bits 15:8 |
| pat_flat | input | 128 | Eight 16-bit pattern entries, entry k at bits 16k+15:16k |
| alarm_out | output | 16 | Registered sticky per-bit alarm |

## Verification
The assertions need every input to hold a known value at each rising edge after reset. This matters most for sync_in and chk_en, because the edge detector and the pattern lock follow them directly. The checks on the pattern index and on full-word mode also assume the pattern registers and the mode input do not glitch inside a cycle. The stimulus meets these needs by driving every input only on the falling clock edge. It sets every input to a defined level before reset is released, and it leaves the pattern registers unchanged for the whole run.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_FULL = 1'b1
  } word_mode_e;

  localparam int PIC_LANES = 2;

endpackage

// File: rtl/pic_sync_track.sv
module pic_sync_track #(
  parameter int NUM_PAT = 8,
  localparam int IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sync_in,
  output logic             sync_rise,
  output logic             cmp_vld,
  output logic [IDX_W-1:0] sel,
  output logic [IDX_W-1:0] idx
);

  logic             sync_q;
  logic             locked_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_after0;

  assign sync_rise  = en & sync_in & ~sync_q;
  assign cmp_vld    = en & (sync_rise | locked_q);
  assign sel        = sync_rise ? '0 : idx_q;
  assign idx        = idx_q;
  assign idx_after0 = IDX_W'(1 % NUM_PAT);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sync_q   <= 1'b0;
      locked_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      sync_q <= sync_in;
      if (sync_rise) begin
        locked_q <= 1'b1;
        idx_q    <= idx_after0;
      end else if (locked_q) begin
        if (idx_q == IDX_W'(NUM_PAT - 1)) idx_q <= '0;
        else                              idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pic_compare.sv
module pic_compare #(
  parameter int DATA_W  = 16,
  parameter int NUM_PAT = 8,
  localparam int IDX_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic [DATA_W*NUM_PAT-1:0] pat_flat,
  input  logic [IDX_W-1:0]          sel,
  input  logic [DATA_W-1:0]         sample,
  input  logic [DATA_W-1:0]         mask,
  input  logic                      vld,
  output logic [DATA_W-1:0]         miss
);

  logic [DATA_W-1:0] pat_arr [NUM_PAT];
  logic [DATA_W-1:0] ref_word;

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_unpack
    assign pat_arr[k] = pat_flat[k*DATA_W +: DATA_W];
  end

  always_comb begin
    ref_word = '0;
    for (int k = 0; k < NUM_PAT; k++) begin
      if (sel == IDX_W'(k)) ref_word = pat_arr[k];
    end
  end

  assign miss = vld ? ((sample ^ ref_word) & mask) : '0;

endmodule

// File: rtl/pic_alarm.sv
module pic_alarm #(
  parameter int DATA_W   = 16,
  parameter int GOOD_RUN = 64,
  localparam int CNT_W = $clog2(GOOD_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              vld,
  input  logic              sync_rise,
  input  logic [DATA_W-1:0] miss,
  input  logic              clr,
  input  logic              autoclr_en,
  output logic [DATA_W-1:0] alarm,
  output logic [CNT_W-1:0]  good_cnt
);

  logic [DATA_W-1:0] alarm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              any_miss;
  logic              hit_good;
  logic              run_done;
  logic [DATA_W-1:0] base;

  assign any_miss = |miss;
  assign hit_good = vld & ~any_miss;
  assign run_done = hit_good & ~sync_rise & (cnt_q == CNT_W'(GOOD_RUN - 1));

  always_comb begin
    base = alarm_q;
    if (clr || (run_done && autoclr_en)) base = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      alarm_q <= '0;
      cnt_q   <= '0;
    end else begin
      alarm_q <= base | miss;
      if (sync_rise || any_miss || run_done) cnt_q <= '0;
      else if (hit_good)                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign alarm    = alarm_q;
  assign good_cnt = cnt_q;

endmodule

// File: rtl/pattern_checker.sv
module pattern_checker #(
  parameter int HALF_W   = 8,
  parameter int WORD_W   = 14,
  parameter int NUM_PAT  = 8,
  parameter int GOOD_RUN = 64,
  localparam int DATA_W = pic_pkg::PIC_LANES * HALF_W,
  localparam int IDX_W  = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
  localparam int CNT_W  = $clog2(GOOD_RUN + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      chk_en,
  input  logic                      full_word_mode,
  input  logic                      autoclr_en,
  input  logic                      alarm_clr,
  input  logic                      sync_in,
  input  logic [DATA_W-1:0]         sample_in,
  input  logic [DATA_W*NUM_PAT-1:0] pat_flat,
  output logic [DATA_W-1:0]         alarm_out
);

  import pic_pkg::*;

  word_mode_e        mode;
  logic [DATA_W-1:0] mask;
  logic              sync_rise;
  logic              cmp_vld;
  logic [IDX_W-1:0]  sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] miss;
  logic [CNT_W-1:0]  good_cnt;

  assign mode = word_mode_e'(full_word_mode);

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < WORD_W) begin : g_core
      assign mask[b] = 1'b1;
    end else begin : g_ext
      assign mask[b] = (mode == MODE_HALF);
    end
  end

  pic_sync_track #(.NUM_PAT(NUM_PAT)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .en        (chk_en),
    .sync_in   (sync_in),
    .sync_rise (sync_rise),
    .cmp_vld   (cmp_vld),
    .sel       (sel),
    .idx       (idx)
  );

  pic_compare #(.DATA_W(DATA_W), .NUM_PAT(NUM_PAT)) u_cmp (
    .pat_flat (pat_flat),
    .sel      (sel),
    .sample   (sample_in),
    .mask     (mask),
    .vld      (cmp_vld),
    .miss     (miss)
  );

  pic_alarm #(.DATA_W(DATA_W), .GOOD_RUN(GOOD_RUN)) u_alarm (
    .clk        (clk),
    .rst        (rst),
    .en         (chk_en),
    .vld        (cmp_vld),
    .sync_rise  (sync_rise),
    .miss       (miss),
    .clr        (alarm_clr),
    .autoclr_en (autoclr_en),
    .alarm      (alarm_out),
    .good_cnt   (good_cnt)
  );

endmodule

// File: rtl/pattern_checker_chk.sv
module pattern_checker_chk #(
  parameter int DATA_W   = 16,
  parameter int WORD_W   = 14,
  parameter int NUM_PAT  = 8,
  parameter int GOOD_RUN = 64,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_en,
  input logic              full_word_mode,
  input logic              autoclr_en,
  input logic              alarm_clr,
  input logic              sync_rise,
  input logic              cmp_vld,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] miss,
  input logic [CNT_W-1:0]  good_cnt,
  input logic [DATA_W-1:0] alarm_out
);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(NUM_PAT - 1)) ? '0 : i + 1'b1;
  endfunction

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> alarm_out == '0); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld && !sync_rise) |=> idx == step_idx($past(idx))); // R2

  AST_RISE_REALIGN: assert property (@(posedge clk) disable iff (rst)
    sync_rise |=> idx == IDX_W'(1 % NUM_PAT)); // R10

  AST_MISS_WINS: assert property (@(posedge clk) disable iff (rst)
    (miss != '0) |=> (alarm_out & $past(miss)) == $past(miss)); // R5

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !alarm_clr && !autoclr_en) |=>
      (alarm_out & $past(alarm_out)) == $past(alarm_out)); // R4

  AST_FULL_TOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (full_word_mode && alarm_out[DATA_W-1:WORD_W] == '0) |=>
      alarm_out[DATA_W-1:WORD_W] == '0); // R9

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    good_cnt < CNT_W'(GOOD_RUN)); // R6

endmodule

bind pattern_checker pattern_checker_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .NUM_PAT(NUM_PAT),
  .GOOD_RUN(GOOD_RUN), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .chk_en         (chk_en),
  .full_word_mode (full_word_mode),
  .autoclr_en     (autoclr_en),
  .alarm_clr      (alarm_clr),
  .sync_rise      (sync_rise),
  .cmp_vld        (cmp_vld),
  .idx            (idx),
  .miss           (miss),
  .good_cnt       (good_cnt),
  .alarm_out      (alarm_out)
);

// File: tb/tb_pattern_checker.sv
module tb_pattern_checker;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chk_en = 1'b0;
  logic          full_word_mode = 1'b1;
  logic          autoclr_en = 1'b0;
  logic          alarm_clr = 1'b0;
  logic          sync_in = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic [DW*NP-1:0] pat_flat;
  logic [DW-1:0] alarm_out;

  logic [DW-1:0] pat [NP];
  int ptr = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_checker dut (
    .clk(clk), .rst(rst), .chk_en(chk_en), .full_word_mode(full_word_mode),
    .autoclr_en(autoclr_en), .alarm_clr(alarm_clr), .sync_in(sync_in),
    .sample_in(sample_in), .pat_flat(pat_flat), .alarm_out(alarm_out)
  );

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (alarm_out !== exp) begin
      errors++;
      $display("FAIL %s: alarm_out actual=%h expected=%h", req, alarm_out, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic s, input logic [DW-1:0] d, input logic c);
    sync_in = s; sample_in = d; alarm_clr = c;
    @(posedge clk);
    @(negedge clk);
    sync_in = 1'b0; alarm_clr = 1'b0;
  endtask

  task automatic good(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, pat[ptr], 1'b0);
      ptr = (ptr + 1) % NP;
    end
  endtask

  task automatic bad(input logic [DW-1:0] flip, input logic c);
    step(1'b0, pat[ptr] ^ flip, c);
    ptr = (ptr + 1) % NP;
  endtask

  task automatic sync_go();
    step(1'b1, pat[0], 1'b0);
    ptr = 1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", '0);
  endtask

  task automatic t_presync();
    chk_en = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, ~pat[i], 1'b0);
    check("R3", '0);
  endtask

  task automatic t_align();
    sync_go();
    good(15);
    check("R2", '0);
    bad(16'h0004, 1'b0);
    check("R4", 16'h0004);
    good(3);
    bad(16'h0200, 1'b0);
    check("R4", 16'h0204);
  endtask

  task automatic t_clear();
    step(1'b0, pat[ptr], 1'b1); ptr = (ptr + 1) % NP;
    check("R5", '0);
    bad(16'h0010, 1'b1);
    check("R5", 16'h0010);
    step(1'b0, pat[ptr], 1'b1); ptr = (ptr + 1) % NP;
    check("R5", '0);
  endtask

  task automatic t_noauto();
    bad(16'h0001, 1'b0);
    good(70);
    check("R7", 16'h0001);
  endtask

  task automatic t_auto();
    autoclr_en = 1'b1;
    bad(16'h0002, 1'b0);
    good(63);
    check("R6", 16'h0003);
    good(1);
    check("R6", '0);
    bad(16'h0008, 1'b0);
    good(40);
    bad(16'h0008, 1'b0);
    good(63);
    check("R6", 16'h0008);
    good(1);
    check("R6", '0);
    autoclr_en = 1'b0;
  endtask

  task automatic t_resync();
    good(2);
    if (ptr == 0) good(1);
    sync_go();
    good(10);
    check("R10", '0);
  endtask

  task automatic t_width();
    full_word_mode = 1'b1;
    bad(16'hC000, 1'b0);
    check("R9", '0);
    full_word_mode = 1'b0;
    bad(16'h8080, 1'b0);
    check("R9", 16'h8080);
    step(1'b0, pat[ptr], 1'b1); ptr = (ptr + 1) % NP;
    full_word_mode = 1'b1;
    check("R9", '0);
  endtask

  task automatic t_disable();
    bad(16'h0020, 1'b0);
    check("R4", 16'h0020);
    chk_en = 1'b0;
    step(1'b0, 16'hFFFF, 1'b0);
    check("R8", '0);
    for (int i = 0; i < 4; i++) step(i[0], 16'h1234, 1'b0);
    check("R8", '0);
    chk_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, ~pat[i], 1'b0);
    check("R8", '0);
    sync_go();
    good(8);
    check("R8", '0);
    bad(16'h0100, 1'b0);
    check("R8", 16'h0100);
  endtask

  initial begin
    for (int k = 0; k < NP; k++) begin
      pat[k] = 16'h3A5C ^ DW'((k + 1) * 16'h0F21);
      pat_flat[k*DW +: DW] = pat[k];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_presync();
    t_align();
    t_clear();
    t_noauto();
    t_auto();
    t_resync();
    t_width();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule